// File: doc/BRIEF.md
# Double-Latched Programmable Feedback Divider

This block divides a fast input clock (the already prescaled oscillator signal) by a programmable 15-bit ratio N. A down-counter marks the end of each division period with a single-cycle pulse and reloads itself for the next period. A divide-by-two copy of that pulse train is kept for test observation.

New ratios arrive on a valid/ready write port at any time, with no regard to where the counter is in its period. Each accepted ratio goes into a holding stage. It moves into an active stage only on the cycle in which the counter reaches its terminal count, and the counter reloads from that same transfer path. The counter therefore never runs a period with a half-updated ratio. Ratios below the legal minimum are raised to the minimum when they are stored. After reset a fixed ratio is in force, so the divider runs before any write arrives.

Back-pressure rules: `wr_ready` is low while reset is held and for the first clock edge after reset release. From then on it is high on every cycle. A ratio is taken on each rising edge where `wr_valid` and `wr_ready` are both high. The block never stalls a writer. When several writes land within one period, the last one wins.

Top module: `fbdiv_dual_latch`

## Requirements
- R1: While reset is held, `div_pulse`, `div_half` and `wr_ready` are 0. After reset release with no write, the first `div_pulse` appears after exactly RESET_RATIO (default 256) rising edges. Every later period is also RESET_RATIO cycles long.
- R2: `div_pulse` is high for exactly one clock cycle per period. Consecutive pulses are N cycles apart, where N is the active ratio. The ratio is `wr_ratio` read as plain unsigned binary, with bit i weighing 2^i.
- R3: An accepted ratio governs the period that begins at the first terminal count after the write edge. A write on the same edge as a terminal count governs the period after that one. A period already in progress keeps its length.
- R4: A written value below MIN_RATIO (default 17), including 0 and 16, is stored as MIN_RATIO. A value of 17 or 18 is used unchanged.
- R5: The largest ratio, 32767 (all 15 bits set), gives a period of 32767 cycles.
- R6: `div_half` is 0 after reset. It inverts on the clock edge that ends each `div_pulse` cycle and holds its value otherwise.
- R7: `wr_ready` is 1 from the second rising edge after reset release onward. `wr_ratio` is ignored while `wr_valid` is low. The last write accepted within a period is the one that takes effect.
- R8: With no further writes, the last active ratio keeps repeating period after period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaled oscillator clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A new ratio is offered on `wr_ratio` |
| wr_ready | output | 1 | The holding stage accepts a ratio this cycle |
| wr_ratio | input | CNT_W | Requested division ratio, unsigned binary |
| div_pulse | output | 1 | One-cycle pulse at each terminal count (divided output) |
| div_half | output | 1 | Divided output halved, for test observation |

## Verification
The bench builds the block with its default parameters: a 15-bit counter, a minimum of 17 and a reset ratio of 256. At that width the full 32767-cycle period and the 256-cycle reset period both fit in one run. The small minimum lets many short periods and clamped writes fit around them. Random writes with random gaps land at every phase of the count, including the terminal-count edge itself. The bench compares every pulse spacing and every value of the halved output against a model of the two-stage transfer rule.

// File: rtl/fbdiv_pkg.sv
`timescale 1ns/1ps
package fbdiv_pkg;

  // Raise a requested ratio to the lowest legal value.
  function automatic logic [31:0] clamp_low(input logic [31:0] req,
                                            input logic [31:0] floor_val);
    return (req < floor_val) ? floor_val : req;
  endfunction

endpackage

// File: rtl/fbdiv_hold_stage.sv
`timescale 1ns/1ps
module fbdiv_hold_stage #(
  parameter int CNT_W       = 15,
  parameter int MIN_RATIO   = 17,
  parameter int RESET_RATIO = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [CNT_W-1:0] wr_ratio,
  output logic             wr_ready,
  output logic [CNT_W-1:0] hold_q
);
  import fbdiv_pkg::*;

  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_RATIO);

  logic             ready_q;
  logic             fire;
  logic [CNT_W-1:0] clamped;

  assign wr_ready = ready_q;
  assign fire     = wr_valid && ready_q;
  assign clamped  = CNT_W'(clamp_low(32'(wr_ratio), 32'(FLOOR)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      hold_q  <= CNT_W'(RESET_RATIO);
    end else begin
      ready_q <= 1'b1;
      if (fire) hold_q <= clamped;
    end
  end

  // R4: a stored ratio is never below the floor
  p_clamp_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> hold_q >= FLOOR);
  // R4: legal values are stored unchanged
  p_legal_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wr_ratio >= FLOOR) |=> hold_q == $past(wr_ratio));
  // R7: without a handshake the holding stage is untouched
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(hold_q));

endmodule

// File: rtl/fbdiv_active_stage.sv
`timescale 1ns/1ps
module fbdiv_active_stage #(
  parameter int CNT_W       = 15,
  parameter int MIN_RATIO   = 17,
  parameter int RESET_RATIO = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer,
  input  logic [CNT_W-1:0] hold_q,
  output logic [CNT_W-1:0] active_q,
  output logic [CNT_W-1:0] active_next
);

  assign active_next = xfer ? hold_q : active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) active_q <= CNT_W'(RESET_RATIO);
    else        active_q <= active_next;
  end

  // R3: the active ratio changes only at terminal count
  p_active_only_on_tc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(active_q));
  // R3: at terminal count the active stage takes the held ratio
  p_active_takes_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> active_q == $past(hold_q));
  // R4: the active ratio stays legal
  p_active_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active_q >= CNT_W'(MIN_RATIO));

endmodule

// File: rtl/fbdiv_downcount.sv
`timescale 1ns/1ps
module fbdiv_downcount #(
  parameter int CNT_W       = 15,
  parameter int RESET_RATIO = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] load_ratio,
  output logic             tc
);

  logic [CNT_W-1:0] cnt_q;

  assign tc = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)  cnt_q <= CNT_W'(RESET_RATIO);
    else if (tc) cnt_q <= load_ratio - 1'b1;
    else         cnt_q <= cnt_q - 1'b1;
  end

  // R2: between terminal counts the counter steps down by one
  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tc |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/fbdiv_halver.sv
`timescale 1ns/1ps
module fbdiv_halver (
  input  logic clk,
  input  logic rst_n,
  input  logic tc,
  output logic half_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  half_q <= 1'b0;
    else if (tc) half_q <= ~half_q;
  end

  // R6: halved output inverts after each pulse
  p_half_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> half_q != $past(half_q));
  // R6: and holds otherwise
  p_half_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tc |=> $stable(half_q));

endmodule

// File: rtl/fbdiv_dual_latch.sv
`timescale 1ns/1ps
module fbdiv_dual_latch #(
  parameter int CNT_W       = 15,
  parameter int MIN_RATIO   = 17,
  parameter int RESET_RATIO = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [CNT_W-1:0] wr_ratio,
  output logic             div_pulse,
  output logic             div_half
);

  localparam int MAX_RATIO = (1 << CNT_W) - 1;

  if (MIN_RATIO < 2 || MIN_RATIO > MAX_RATIO) begin : g_bad_min
    $error("MIN_RATIO out of range");
  end
  if (RESET_RATIO < MIN_RATIO || RESET_RATIO > MAX_RATIO) begin : g_bad_reset
    $error("RESET_RATIO out of range");
  end

  logic [CNT_W-1:0] hold_q;
  logic [CNT_W-1:0] active_q;
  logic [CNT_W-1:0] active_next;
  logic             tc;

  fbdiv_hold_stage #(
    .CNT_W(CNT_W), .MIN_RATIO(MIN_RATIO), .RESET_RATIO(RESET_RATIO)
  ) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ratio(wr_ratio),
    .wr_ready(wr_ready), .hold_q(hold_q)
  );

  fbdiv_active_stage #(
    .CNT_W(CNT_W), .MIN_RATIO(MIN_RATIO), .RESET_RATIO(RESET_RATIO)
  ) u_active (
    .clk(clk), .rst_n(rst_n), .xfer(tc), .hold_q(hold_q),
    .active_q(active_q), .active_next(active_next)
  );

  fbdiv_downcount #(
    .CNT_W(CNT_W), .RESET_RATIO(RESET_RATIO)
  ) u_count (
    .clk(clk), .rst_n(rst_n), .load_ratio(active_next), .tc(tc)
  );

  fbdiv_halver u_half (
    .clk(clk), .rst_n(rst_n), .tc(tc), .half_q(div_half)
  );

  assign div_pulse = tc;

  // R2: the divided output is a single-cycle pulse
  p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);
  // R7: once ready, the port stays ready
  p_ready_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |=> wr_ready);
  // R3: the active ratio only moves while a pulse is seen
  p_active_moves_at_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q != $past(active_q)) |-> $past(div_pulse));

endmodule

// File: tb/fbdiv_dual_latch_tb_top.sv
`timescale 1ns/1ps
module fbdiv_dual_latch_tb_top;

  localparam int W = 15;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_valid;
  logic         wr_ready;
  logic [W-1:0] wr_ratio;
  logic         div_pulse;
  logic         div_half;

  int n_checks = 0;
  int n_fails  = 0;

  // bench model state
  int a_model, exp_period, gap, npulse;
  bit cur_pulse, half_model, ready_obs;
  string cur_req;

  always #10 clk = ~clk;

  fbdiv_dual_latch #(.CNT_W(15), .MIN_RATIO(17), .RESET_RATIO(256)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_ratio(wr_ratio), .div_pulse(div_pulse), .div_half(div_half)
  );

  function automatic int exp_ratio(input int d);
    return (d < 17) ? 17 : d;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock: drive after a falling edge, sample at the next falling edge.
  task automatic tick(input bit v, input int d);
    wr_valid = v;
    wr_ratio = W'(d);
    if (cur_pulse) exp_period = a_model;
    if (v && ready_obs) a_model = exp_ratio(d);
    if (cur_pulse) half_model = ~half_model;
    @(negedge clk);
    gap++;
    ready_obs = wr_ready;
    cur_pulse = div_pulse;
    if (div_pulse || gap == exp_period) begin
      chk(div_pulse && gap == exp_period, cur_req, gap, exp_period);
      if (div_pulse) begin
        chk(div_half == half_model, "R6", div_half, half_model);
        npulse++;
        gap = 0;
      end
    end
  endtask

  task automatic wr(input int d);
    tick(1'b1, d);
  endtask

  task automatic run_pulses(input int n);
    int target;
    target = npulse + n;
    while (npulse < target) tick(1'b0, int'($urandom_range(0, 32767)));
  endtask

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_ratio = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(div_pulse == 1'b0, "R1 pulse in reset", div_pulse, 0);
    chk(div_half == 1'b0, "R1 half in reset", div_half, 0);
    chk(wr_ready == 1'b0, "R1 ready in reset", wr_ready, 0);
    rst_n = 1'b1;
    a_model = 256; exp_period = 256; gap = 0; npulse = 0;
    cur_pulse = 1'b0; half_model = 1'b0; ready_obs = 1'b0;
    cur_req = "R1 first period";
    tick(1'b0, 0);
    chk(ready_obs == 1'b1, "R7 ready after reset", ready_obs, 1);
    run_pulses(1);
    cur_req = "R8 repeat reset ratio";
    run_pulses(2);

    // R4: floor and near-floor values
    cur_req = "R4 ratio 17";  wr(17); run_pulses(2);
    cur_req = "R4 ratio 0";   wr(0);  run_pulses(2);
    cur_req = "R4 ratio 16";  wr(16); run_pulses(2);
    cur_req = "R4 ratio 5";   wr(5);  run_pulses(2);
    cur_req = "R4 ratio 18";  wr(18); run_pulses(2);

    // R3: write on the terminal-count edge
    cur_req = "R3 write at tc";
    while (!cur_pulse) tick(1'b0, 0);
    wr(40); run_pulses(3);

    // R7: last write in a period wins; valid low ignored
    cur_req = "R7 last write wins";
    wr(100); tick(1'b0, 0); wr(50); tick(1'b0, 23); run_pulses(3);

    // R5: maximum ratio
    cur_req = "R5 max ratio";
    wr(32767); run_pulses(1); wr(20); run_pulses(3);

    // R2: random ratios at random phases
    cur_req = "R2 random ratio";
    for (int i = 0; i < 60; i++) begin
      int d;
      if ($urandom_range(0, 3) == 0) d = int'($urandom_range(0, 40));
      else d = int'($urandom_range(17, 600));
      wr(d);
      repeat ($urandom_range(0, 700)) tick(1'b0, int'($urandom_range(0, 32767)));
    end
    run_pulses(2);
    cur_req = "R8 hold last ratio";
    run_pulses(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(20 * 190000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", npulse, -1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule